// File: doc/BRIEF.md
# Cache Tag Directory with Hit Compare

This block is the tag directory of a secondary cache. Every line index selects one entry holding a tag field and three status flags: valid, dirty and write-through. The presented tag is compared with the stored tag at the current index without waiting for a clock, and the `hit` output reports the result. In dedicated-status mode the result is qualified by the stored valid flag. In generic mode the flags are plain user storage and `hit` reports tag equality alone.

Reads of the tag and status fields also follow the index without a clock. Writes to either field take effect at a rising clock edge. Each field has its own write strobe and its own read enable. A synchronous clear input invalidates every entry in one cycle. The outputs that would be three-state pins are modelled here as a data value plus a drive flag. An output that is not driven reads zero.

Top module: `tag_dir_store`

## Requirements
- R1: With the block selected and awake, `clr_n` high and `tag_wr` high at a rising edge, `tag_in` is stored at `addr`. Afterwards, with `tag_rd_en` high, `tag_out` shows the stored tag combinationally and `tag_drv` is 1.
- R2: A tag write leaves the status flags of the entry unchanged, and a status write leaves the tag unchanged.
- R3: Status bit 0 is valid, bit 1 is dirty and bit 2 is write-through. `stat_wr` stores `stat_in` at a rising edge. With `stat_rd_en` high, `stat_out` shows the stored flags and `stat_drv` is 1.
- R4: With `generic_mode` low, `hit` is 1 only when the stored tag equals `tag_in` and the stored valid bit is 1.
- R5: With `generic_mode` high, `hit` depends on tag equality only, whatever the stored valid bit is.
- R6: `hit` is 0 while `tag_rd_en`, `tag_wr` or `stat_wr` is high, or while `clr_n` is low.
- R7: `clr_n` low at a rising edge clears every status flag of every entry. A tag or status write presented at that same edge is dropped.
- R8: During a write, the write data appears on the matching output: `tag_in` on `tag_out`, `stat_in` on `stat_out`, with the drive flag set.
- R9: The block is selected only when `sel_a_n` is 0 and `sel_b` is 1. When it is not selected, all three drive flags are 0, all outputs read 0 and writes are ignored.
- R10: While `sleep` is 1, all drive flags are 0 and tag and status writes are ignored.
- R11: `rst_n` low clears all status flags asynchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for writes and clear |
| rst_n | input | 1 | Asynchronous active-low reset of the status flags |
| addr | input | ADDR_W | Entry index |
| sel_a_n | input | 1 | Active-low select |
| sel_b | input | 1 | Active-high select |
| sleep | input | 1 | Power-down: outputs undriven, writes ignored |
| clr_n | input | 1 | Synchronous active-low invalidate of all entries |
| generic_mode | input | 1 | 1: flags are generic storage; 0: valid qualifies hit |
| tag_rd_en | input | 1 | Tag output enable |
| tag_wr | input | 1 | Tag write strobe |
| tag_in | input | TAG_W | Tag to write and to compare |
| tag_out | output | TAG_W | Tag read data |
| tag_drv | output | 1 | Tag output driven |
| stat_rd_en | input | 1 | Status output enable |
| stat_wr | input | 1 | Status write strobe |
| stat_in | input | 3 | Status write data {wt, dirty, valid} |
| stat_out | output | 3 | Status read data |
| stat_drv | output | 1 | Status output driven |
| hit | output | 1 | Tag compare result |
| hit_drv | output | 1 | Hit output driven |

## Verification
The compare is exercised with four input patterns:
- A matching tag on a valid entry.
- A mismatching tag on the same entry, which separates a real comparison from a stuck output.
- A matching tag on an invalid entry, in both status modes, which separates valid qualification from plain equality.
- A matching tag presented while a read or write is under way, which shows the forcing to 0.

Writes are replayed while deselected and while asleep, and then read back, so that an ignored write becomes visible at the ports. A clear that arrives together with writes shows both that every flag is wiped and that the concurrent writes are dropped.

// File: rtl/tds_pkg.sv
package tds_pkg;
  localparam int STAT_W = 3;

  // bit 0 valid, bit 1 dirty, bit 2 write-through
  typedef struct packed {
    logic wt;
    logic dirty;
    logic valid;
  } stat_t;
endpackage

// File: rtl/tds_tag_array.sv
module tds_tag_array #(
  parameter int ADDR_W = 6,
  parameter int TAG_W  = 12
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [TAG_W-1:0]  wdata,
  output logic [TAG_W-1:0]  rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [TAG_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[addr] <= wdata;
    end
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/tds_status_array.sv
module tds_status_array
  import tds_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           clr,
  input  logic                           we,
  input  logic [ADDR_W-1:0]              addr,
  input  stat_t                          wdata,
  output stat_t                          rdata,
  output logic [STAT_W*(1<<ADDR_W)-1:0]  flat
);
  localparam int DEPTH = 1 << ADDR_W;

  stat_t ent [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    stat_t cur_q;
    stat_t nxt;
    logic  wr_e;

    assign wr_e = we && (addr == ADDR_W'(e));

    always_comb begin
      nxt = cur_q;
      if (clr) begin
        nxt = '0;
      end else if (wr_e) begin
        nxt = wdata;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cur_q <= '0;
      end else begin
        cur_q <= nxt;
      end
    end

    assign ent[e] = cur_q;
    assign flat[e*STAT_W +: STAT_W] = cur_q;
  end

  assign rdata = ent[addr];
endmodule

// File: rtl/tds_hit_logic.sv
module tds_hit_logic #(
  parameter int TAG_W = 12
) (
  input  logic             sel,
  input  logic             block,
  input  logic             generic_mode,
  input  logic             valid,
  input  logic [TAG_W-1:0] stored,
  input  logic [TAG_W-1:0] probe,
  output logic             hit
);
  logic [TAG_W-1:0] diff;
  logic             eq;
  logic             qual;

  assign diff = stored ^ probe;
  assign eq   = (diff == '0);
  assign qual = generic_mode | valid;

  always_comb begin
    hit = 1'b0;
    if (sel && !block) begin
      hit = eq & qual;
    end
  end
endmodule

// File: rtl/tag_dir_store.sv
module tag_dir_store
  import tds_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int TAG_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              sel_a_n,
  input  logic              sel_b,
  input  logic              sleep,
  input  logic              clr_n,
  input  logic              generic_mode,
  input  logic              tag_rd_en,
  input  logic              tag_wr,
  input  logic [TAG_W-1:0]  tag_in,
  output logic [TAG_W-1:0]  tag_out,
  output logic              tag_drv,
  input  logic              stat_rd_en,
  input  logic              stat_wr,
  input  logic [2:0]        stat_in,
  output logic [2:0]        stat_out,
  output logic              stat_drv,
  output logic              hit,
  output logic              hit_drv
);
  localparam int DEPTH = 1 << ADDR_W;

  logic                      sel;
  logic                      tag_we;
  logic                      stat_we;
  logic                      blk;
  logic [TAG_W-1:0]          tag_rd;
  stat_t                     st_rd;
  stat_t                     st_wd;
  logic [STAT_W*DEPTH-1:0]   stat_flat;

  assign sel     = !sel_a_n && sel_b && !sleep;
  assign tag_we  = sel && tag_wr && clr_n;
  assign stat_we = sel && stat_wr && clr_n;
  assign blk     = tag_rd_en || tag_wr || stat_wr || !clr_n;
  assign st_wd   = stat_t'(stat_in);

  tds_tag_array #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_tags (
    .clk   (clk),
    .we    (tag_we),
    .addr  (addr),
    .wdata (tag_in),
    .rdata (tag_rd)
  );

  tds_status_array #(.ADDR_W(ADDR_W)) u_stat (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (!clr_n),
    .we    (stat_we),
    .addr  (addr),
    .wdata (st_wd),
    .rdata (st_rd),
    .flat  (stat_flat)
  );

  tds_hit_logic #(.TAG_W(TAG_W)) u_hit (
    .sel          (sel),
    .block        (blk),
    .generic_mode (generic_mode),
    .valid        (st_rd.valid),
    .stored       (tag_rd),
    .probe        (tag_in),
    .hit          (hit)
  );

  always_comb begin
    tag_drv = sel && (tag_rd_en || tag_wr);
    tag_out = '0;
    if (tag_drv) begin
      tag_out = tag_wr ? tag_in : tag_rd;
    end
  end

  always_comb begin
    stat_drv = sel && (stat_rd_en || stat_wr);
    stat_out = '0;
    if (stat_drv) begin
      stat_out = stat_wr ? stat_in : 3'(st_rd);
    end
  end

  assign hit_drv = sel;
endmodule

// File: rtl/tds_checker.sv
module tds_checker #(
  parameter int ADDR_W = 6
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      sleep,
  input logic                      clr_n,
  input logic                      generic_mode,
  input logic                      tag_rd_en,
  input logic                      tag_wr,
  input logic                      stat_wr,
  input logic                      hit,
  input logic                      hit_drv,
  input logic                      tag_drv,
  input logic                      stat_drv,
  input logic                      rd_valid,
  input logic [3*(1<<ADDR_W)-1:0]  stat_flat
);
  assert_hit_needs_select_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> hit_drv);

  assert_hit_needs_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !generic_mode) |-> rd_valid);

  assert_hit_forced_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_rd_en || tag_wr || stat_wr) |-> !hit);

  assert_clear_wipes_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> (stat_flat == '0));

  assert_sleep_undriven_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> (!tag_drv && !stat_drv && !hit_drv));
endmodule

bind tag_dir_store tds_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sleep        (sleep),
  .clr_n        (clr_n),
  .generic_mode (generic_mode),
  .tag_rd_en    (tag_rd_en),
  .tag_wr       (tag_wr),
  .stat_wr      (stat_wr),
  .hit          (hit),
  .hit_drv      (hit_drv),
  .tag_drv      (tag_drv),
  .stat_drv     (stat_drv),
  .rd_valid     (st_rd.valid),
  .stat_flat    (stat_flat)
);

// File: tb/tag_dir_store_tb.sv
`timescale 1ns/1ps
module tag_dir_store_tb;
  localparam int AW    = 4;
  localparam int TW    = 12;
  localparam int DEPTH = 1 << AW;

  logic          clk;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic          sel_a_n, sel_b, sleep, clr_n, generic_mode;
  logic          tag_rd_en, tag_wr, stat_rd_en, stat_wr;
  logic [TW-1:0] tag_in, tag_out;
  logic [2:0]    stat_in, stat_out;
  logic          tag_drv, stat_drv, hit, hit_drv;

  int checks = 0;
  int fails  = 0;
  int tagm  [DEPTH];
  int statm [DEPTH];

  tag_dir_store #(.ADDR_W(AW), .TAG_W(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .sel_a_n(sel_a_n), .sel_b(sel_b),
    .sleep(sleep), .clr_n(clr_n), .generic_mode(generic_mode),
    .tag_rd_en(tag_rd_en), .tag_wr(tag_wr), .tag_in(tag_in), .tag_out(tag_out),
    .tag_drv(tag_drv), .stat_rd_en(stat_rd_en), .stat_wr(stat_wr),
    .stat_in(stat_in), .stat_out(stat_out), .stat_drv(stat_drv),
    .hit(hit), .hit_drv(hit_drv)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int tagv(int i);
    return (i * 389 + 77) & 12'hfff;
  endfunction

  task automatic chk(string rq, string nm, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, nm, act, exp);
    end
  endtask

  task automatic step(string rq, int a, bit sa_n, bit sb, bit slp, bit clr,
                      bit gen, bit tre, bit twr, int tin, bit sre, bit swr, int sin);
    bit s, td, sd, h;
    int to, so;
    addr = AW'(a); sel_a_n = sa_n; sel_b = sb; sleep = slp; clr_n = clr;
    generic_mode = gen; tag_rd_en = tre; tag_wr = twr; tag_in = TW'(tin);
    stat_rd_en = sre; stat_wr = swr; stat_in = 3'(sin);
    #1;
    s  = !sa_n && sb && !slp;
    td = s && (tre || twr);
    sd = s && (sre || swr);
    to = td ? (twr ? tin : tagm[a]) : 0;
    so = sd ? (swr ? sin : statm[a]) : 0;
    h  = s && !tre && !twr && !swr && clr && (tagm[a] == tin) &&
         (gen || ((statm[a] & 1) == 1));
    chk(rq, "tag_drv", int'(tag_drv), int'(td));
    chk(rq, "tag_out", int'(tag_out), to);
    chk(rq, "stat_drv", int'(stat_drv), int'(sd));
    chk(rq, "stat_out", int'(stat_out), so);
    chk(rq, "hit_drv", int'(hit_drv), int'(s));
    chk(rq, "hit", int'(hit), int'(h));
    @(posedge clk);
    if (!clr) begin
      for (int k = 0; k < DEPTH; k++) statm[k] = 0;
    end else if (s) begin
      if (twr) tagm[a] = tin;
      if (swr) statm[a] = sin;
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int k = 0; k < DEPTH; k++) begin tagm[k] = 0; statm[k] = 0; end
    rst_n = 1'b0; addr = '0; sel_a_n = 1'b1; sel_b = 1'b0; sleep = 1'b0;
    clr_n = 1'b1; generic_mode = 1'b0; tag_rd_en = 1'b0; tag_wr = 1'b0;
    tag_in = '0; stat_rd_en = 1'b0; stat_wr = 1'b0; stat_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: status flags read zero after reset
    step("R11", 3, 0,1,0,1, 0, 0,0,0, 1,0,0);
    // R1 / R8: fill the tag array, write data passes through
    for (int i = 0; i < DEPTH; i++) step("R8", i, 0,1,0,1, 0, 0,1,tagv(i), 0,0,0);
    for (int i = 0; i < DEPTH; i += 5) step("R1", i, 0,1,0,1, 0, 1,0,0, 0,0,0);
    // R2 / R3: status writes keep the tag
    step("R3", 2, 0,1,0,1, 0, 0,0,0, 0,1,3'b001);
    step("R3", 7, 0,1,0,1, 0, 0,0,0, 0,1,3'b110);
    step("R2", 2, 0,1,0,1, 0, 1,0,0, 1,0,0);
    step("R2", 7, 0,1,0,1, 0, 0,1,12'h5a5, 1,0,0);
    step("R3", 7, 0,1,0,1, 0, 1,0,0, 1,0,0);
    // R4: dedicated mode compare
    step("R4", 2, 0,1,0,1, 0, 0,0,tagv(2), 0,0,0);
    step("R4", 2, 0,1,0,1, 0, 0,0,tagv(2) ^ 1, 0,0,0);
    step("R4", 5, 0,1,0,1, 0, 0,0,tagv(5), 0,0,0);
    // R5: generic mode ignores valid
    step("R5", 5, 0,1,0,1, 1, 0,0,tagv(5), 0,0,0);
    step("R5", 5, 0,1,0,1, 1, 0,0,tagv(6), 0,0,0);
    // R6: hit forced low during read or write
    step("R6", 2, 0,1,0,1, 0, 1,0,tagv(2), 0,0,0);
    step("R6", 2, 0,1,0,1, 0, 0,0,tagv(2), 0,1,3'b001);
    step("R6", 2, 0,1,0,1, 0, 0,0,tagv(2), 0,0,0);
    // R9: deselected writes ignored, outputs undriven
    step("R9", 2, 1,1,0,1, 0, 1,1,12'habc, 1,1,3'b000);
    step("R9", 2, 0,0,0,1, 0, 1,1,12'habc, 1,1,3'b000);
    step("R9", 2, 0,1,0,1, 0, 1,0,0, 1,0,0);
    // R10: sleep
    step("R10", 2, 0,1,1,1, 0, 1,1,12'h111, 1,1,3'b000);
    step("R10", 2, 0,1,0,1, 0, 1,0,0, 1,0,0);
    step("R10", 2, 0,1,0,1, 0, 0,0,tagv(2), 0,0,0);
    // R7: clear wipes all flags and drops concurrent writes
    step("R7", 9, 0,1,0,1, 0, 0,0,0, 0,1,3'b111);
    step("R7", 9, 0,1,0,0, 0, 0,1,12'h777, 0,1,3'b111);
    step("R7", 9, 0,1,0,1, 0, 1,0,0, 1,0,0);
    step("R7", 7, 0,1,0,1, 0, 0,0,0, 1,0,0);
    step("R7", 2, 0,1,0,1, 0, 0,0,tagv(2), 1,0,0);
    step("R5", 2, 0,1,0,1, 1, 0,0,tagv(2), 0,0,0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule